// File: doc/BRIEF.md
# Amplitude-Indexed Tap Gain Table Generator

This block supplies the per-tap complex gains of a memory-polynomial predistorter. Each tap owns a table of precomputed gains, one entry per amplitude bin, so that an entry already holds the polynomial sum of that tap's coefficients weighted by powers of the sample amplitude. Changing the polynomial order changes only what is stored in the tables. The table layout stays the same.

Each input phase has one address generator. It squares and sums the I and Q parts of the incoming sample, scales the result to the table depth and saturates it. The resulting index enters a shared delay line. Tap m then reads its table with the index of the sample that lies m positions earlier in the sample stream. When the sample rate exceeds the clock rate, two phases arrive per clock. In that mode each tap's table serves both phases through a second read port, so no extra storage is added. While the datapath keeps streaming, adaptation logic can rewrite table entries through a write port.

Top module: `ampidx_tap_gain`

## Requirements
- R1: The table index of a sample is (I*I + Q*Q) shifted right by 2*DATA_W-1-IDX_W bits. I and Q are signed two's complement. A zero sample gives index 0.
- R2: When the shifted value reaches 2^IDX_W or more, the index saturates at 2^IDX_W-1 and does not wrap.
- R3: The gain of phase p, tap m appears on `gain_o` bits [(p*NTAPS+m)*GAIN_W +: GAIN_W]. A sample captured at clock edge k selects a gain that is visible after edge k+1.
- R4: Tap m uses the index of the sample m positions earlier in the combined sample order. Within one clock, phase 0 is the earlier sample of the pair.
- R5: A write selects one tap through `tbl_tap_i`. It changes only that tap's entry at `tbl_addr_i`. A tap value of NTAPS or more changes no entry.
- R6: A write takes effect on the next clock. A read at the following edge returns the new data.
- R7: A read and a write to the same entry at the same edge return the data held before the write.
- R8: In two-phase mode both phases read the same per-tap table. Equal indices on the two phases give equal gains for a given tap.
- R9: While reset is asserted, every gain output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per phase per cycle |
| rst | input | 1 | Synchronous active-high reset |
| smp_re_i | input | PHASES*DATA_W | In-phase parts, phase p at slot p |
| smp_im_i | input | PHASES*DATA_W | Quadrature parts, phase p at slot p |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_tap_i | input | TAP_W | Tap whose table is written |
| tbl_addr_i | input | IDX_W | Entry written |
| tbl_data_i | input | GAIN_W | Packed complex gain written |
| gain_o | output | PHASES*NTAPS*GAIN_W | Per-phase, per-tap gains |

## Verification
The bench builds the block with two phases, three taps, 8-bit samples, 6-bit indices and 16-bit gains. At that size the bench can write every entry of every table with a distinct value, so each gain output shows exactly which index and tap produced it. With 8-bit samples, full-scale inputs push the shifted power past the table depth, which drives the saturation path. The two-phase build covers the shared second read port and the cross-phase ordering of the delay line. Writes interleaved with streaming reach the same-edge and next-edge update cases.

// File: rtl/ampidx_pkg.sv
package ampidx_pkg;

   // Largest number of samples handled per clock (one per read port).
   localparam int MAX_PHASES = 2;

   // Position in the index line (0 = newest sample) read by a phase/tap pair.
   function automatic int line_pos(input int phases, input int phase, input int tap);
      return phases - 1 - phase + tap;
   endfunction

endpackage

// File: rtl/ampidx_addr_gen.sv
module ampidx_addr_gen #(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic signed [DATA_W-1:0] re_i,
   input  logic signed [DATA_W-1:0] im_i,
   output logic        [IDX_W-1:0]  idx_o
);
   localparam int SQ_W  = 2 * DATA_W;
   localparam int SHIFT = SQ_W - 1 - IDX_W;
   localparam logic signed [DATA_W-1:0] MINV = {1'b1, {(DATA_W-1){1'b0}}};

   logic signed [SQ_W-1:0] re_x, im_x, p_re, p_im;
   logic        [SQ_W-1:0] power, scaled;
   logic                   over;
   logic        [IDX_W-1:0] idx_next;

   assign re_x   = SQ_W'(re_i);
   assign im_x   = SQ_W'(im_i);
   assign p_re   = re_x * re_x;
   assign p_im   = im_x * im_x;
   assign power  = p_re + p_im;
   assign scaled = power >> SHIFT;
   assign over   = |scaled[SQ_W-1:IDX_W];
   assign idx_next = over ? {IDX_W{1'b1}} : scaled[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (rst) idx_o <= '0;
      else     idx_o <= idx_next;
   end

   assert_zero_index_R1: assert property (@(posedge clk) disable iff (rst)
      (re_i == '0 && im_i == '0) |=> (idx_o == '0));

   assert_full_scale_clamp_R2: assert property (@(posedge clk) disable iff (rst)
      (re_i == MINV && im_i == MINV) |=> (idx_o == {IDX_W{1'b1}}));

endmodule

// File: rtl/ampidx_index_line.sv
module ampidx_index_line
   import ampidx_pkg::*;
#(
   parameter int PHASES = 1,
   parameter int NTAPS  = 4,
   parameter int IDX_W  = 8
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic [PHASES*IDX_W-1:0]       new_idx_i,
   output logic [PHASES*NTAPS*IDX_W-1:0] addr_o
);
   localparam int LINE = PHASES + NTAPS - 1;
   localparam int OLD  = LINE - PHASES;

   logic [IDX_W-1:0] line_w [LINE];

   // Newest positions come straight from this clock's address generators.
   for (genvar j = 0; j < PHASES; j++) begin : g_new
      assign line_w[j] = new_idx_i[(PHASES-1-j)*IDX_W +: IDX_W];
   end

   // Older positions: registers that advance by PHASES samples per clock.
   if (OLD > 0) begin : g_old
      logic [IDX_W-1:0] old_q [OLD];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 0; k < OLD; k++) old_q[k] <= '0;
         end else begin
            for (int k = 0; k < OLD; k++) old_q[k] <= line_w[k];
         end
      end
      for (genvar k = 0; k < OLD; k++) begin : g_tail
         assign line_w[PHASES+k] = old_q[k];
      end
   end

   for (genvar p = 0; p < PHASES; p++) begin : g_ph
      for (genvar m = 0; m < NTAPS; m++) begin : g_tap
         assign addr_o[(p*NTAPS+m)*IDX_W +: IDX_W] = line_w[line_pos(PHASES, p, m)];
         if (m >= PHASES) begin : g_chk
            assert_tap_delay_R4: assert property (@(posedge clk) disable iff (rst)
               addr_o[(p*NTAPS+m)*IDX_W +: IDX_W] ==
               $past(addr_o[(p*NTAPS+m-PHASES)*IDX_W +: IDX_W]));
         end
      end
   end

endmodule

// File: rtl/ampidx_tap_table.sv
module ampidx_tap_table #(
   parameter int IDX_W    = 8,
   parameter int GAIN_W   = 32,
   parameter int RD_PORTS = 1
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic                         we_i,
   input  logic [IDX_W-1:0]             waddr_i,
   input  logic [GAIN_W-1:0]            wdata_i,
   input  logic [RD_PORTS*IDX_W-1:0]    raddr_i,
   output logic [RD_PORTS*GAIN_W-1:0]   rdata_o
);
   localparam int DEPTH = 1 << IDX_W;

   logic [GAIN_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wdata_i;
   end

   for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      logic [GAIN_W-1:0] rd_q;
      always_ff @(posedge clk) begin
         if (rst) rd_q <= '0;
         else     rd_q <= mem[raddr_i[r*IDX_W +: IDX_W]];
      end
      assign rdata_o[r*GAIN_W +: GAIN_W] = rd_q;

      assert_wr_next_clk_R6: assert property (@(posedge clk) disable iff (rst)
         we_i ##1 (raddr_i[r*IDX_W +: IDX_W] == $past(waddr_i))
         |=> (rdata_o[r*GAIN_W +: GAIN_W] == $past(wdata_i, 2)));
   end

endmodule

// File: rtl/ampidx_tap_gain.sv
module ampidx_tap_gain
   import ampidx_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int IDX_W  = 8,
   parameter int NTAPS  = 4,
   parameter int GAIN_W = 32,
   parameter int PHASES = 1,
   localparam int TAP_W = (NTAPS > 1) ? $clog2(NTAPS) : 1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic [PHASES*DATA_W-1:0]       smp_re_i,
   input  logic [PHASES*DATA_W-1:0]       smp_im_i,
   input  logic                           tbl_we_i,
   input  logic [TAP_W-1:0]               tbl_tap_i,
   input  logic [IDX_W-1:0]               tbl_addr_i,
   input  logic [GAIN_W-1:0]              tbl_data_i,
   output logic [PHASES*NTAPS*GAIN_W-1:0] gain_o
);
   if (PHASES < 1 || PHASES > MAX_PHASES) begin : g_bad_phases
      $error("ampidx_tap_gain: PHASES must be 1 or 2");
   end
   if (IDX_W < 1 || IDX_W > 2*DATA_W-1) begin : g_bad_idx
      $error("ampidx_tap_gain: IDX_W out of range for DATA_W");
   end
   if (NTAPS < 1) begin : g_bad_taps
      $error("ampidx_tap_gain: NTAPS must be at least 1");
   end

   logic [PHASES*IDX_W-1:0]       idx_w;
   logic [PHASES*NTAPS*IDX_W-1:0] addr_w;

   // One address generator per input phase.
   for (genvar p = 0; p < PHASES; p++) begin : g_ag
      ampidx_addr_gen #(
         .DATA_W (DATA_W),
         .IDX_W  (IDX_W)
      ) u_ag (
         .clk   (clk),
         .rst   (rst),
         .re_i  (smp_re_i[p*DATA_W +: DATA_W]),
         .im_i  (smp_im_i[p*DATA_W +: DATA_W]),
         .idx_o (idx_w[p*IDX_W +: IDX_W])
      );
   end

   ampidx_index_line #(
      .PHASES (PHASES),
      .NTAPS  (NTAPS),
      .IDX_W  (IDX_W)
   ) u_line (
      .clk       (clk),
      .rst       (rst),
      .new_idx_i (idx_w),
      .addr_o    (addr_w)
   );

   // One table per tap; every phase reads it through its own port.
   for (genvar m = 0; m < NTAPS; m++) begin : g_tap
      logic [PHASES*IDX_W-1:0]  ra;
      logic [PHASES*GAIN_W-1:0] rd;
      logic                     we;

      assign we = tbl_we_i && (tbl_tap_i == TAP_W'(m));

      for (genvar p = 0; p < PHASES; p++) begin : g_port
         assign ra[p*IDX_W +: IDX_W] = addr_w[(p*NTAPS+m)*IDX_W +: IDX_W];
         assign gain_o[(p*NTAPS+m)*GAIN_W +: GAIN_W] = rd[p*GAIN_W +: GAIN_W];
      end

      ampidx_tap_table #(
         .IDX_W    (IDX_W),
         .GAIN_W   (GAIN_W),
         .RD_PORTS (PHASES)
      ) u_tbl (
         .clk     (clk),
         .rst     (rst),
         .we_i    (we),
         .waddr_i (tbl_addr_i),
         .wdata_i (tbl_data_i),
         .raddr_i (ra),
         .rdata_o (rd)
      );
   end

   assert_reset_zero_R9: assert property (@(posedge clk)
      rst |=> (gain_o == '0));

endmodule

// File: tb/ampidx_tap_gain_bench.sv
module ampidx_tap_gain_bench;
   localparam int DW = 8;
   localparam int IW = 6;
   localparam int NT = 3;
   localparam int GW = 16;
   localparam int PH = 2;
   localparam int TW = 2;
   localparam int DEPTH = 1 << IW;
   localparam int LINE = PH + NT - 1;
   localparam int OW = PH * NT * GW;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [PH*DW-1:0] smp_re = '0;
   logic [PH*DW-1:0] smp_im = '0;
   logic          tbl_we = 1'b0;
   logic [TW-1:0] tbl_tap = '0;
   logic [IW-1:0] tbl_addr = '0;
   logic [GW-1:0] tbl_data = '0;
   logic [OW-1:0] gain;

   always #2 clk = ~clk;

   ampidx_tap_gain #(
      .DATA_W (DW), .IDX_W (IW), .NTAPS (NT), .GAIN_W (GW), .PHASES (PH)
   ) u_ampidx_tap_gain (
      .clk (clk), .rst (rst),
      .smp_re_i (smp_re), .smp_im_i (smp_im),
      .tbl_we_i (tbl_we), .tbl_tap_i (tbl_tap),
      .tbl_addr_i (tbl_addr), .tbl_data_i (tbl_data),
      .gain_o (gain)
   );

   typedef struct {
      logic [OW-1:0] exp;
      int            due;
      string         tag;
   } item_t;

   item_t         exp_q[$];
   logic [GW-1:0] tm [NT][DEPTH];
   int            hist [LINE];
   int            cyc = 0;
   int            n_chk = 0;
   int            n_bad = 0;
   bit            finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   // R1/R2 reference: shifted power with saturation.
   function automatic int idx_of(input int re, input int im);
      int v;
      v = (re * re + im * im) >>> (2*DW - 1 - IW);
      if (v > DEPTH - 1) v = DEPTH - 1;
      return v;
   endfunction

   task automatic step(input string tag, input int r0, input int q0,
                       input int r1, input int q1, input bit we,
                       input int wt, input int wa, input int wd, input bit chk);
      item_t it;
      @(negedge clk);
      smp_re   = {r1[DW-1:0], r0[DW-1:0]};
      smp_im   = {q1[DW-1:0], q0[DW-1:0]};
      tbl_we   = we;
      tbl_tap  = wt[TW-1:0];
      tbl_addr = wa[IW-1:0];
      tbl_data = wd[GW-1:0];
      if (we && wt < NT) tm[wt][wa] = wd[GW-1:0];
      for (int j = LINE - 1; j >= PH; j--) hist[j] = hist[j-PH];
      hist[1] = idx_of(r0, q0);
      hist[0] = idx_of(r1, q1);
      if (chk) begin
         it.exp = '0;
         for (int p = 0; p < PH; p++)
            for (int m = 0; m < NT; m++)
               it.exp[(p*NT+m)*GW +: GW] = tm[m][hist[PH-1-p+m]];
         it.due = cyc + 2;
         it.tag = tag;
         exp_q.push_back(it);
      end
   endtask

   // Monitor: pops expected vectors when they fall due.
   always @(negedge clk) begin
      if (!rst) begin
         while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            n_chk++;
            if (gain !== exp_q[0].exp) begin
               n_bad++;
               $display("FAIL %s: gain actual %h expected %h", exp_q[0].tag, gain, exp_q[0].exp);
            end
            void'(exp_q.pop_front());
         end
      end
   end

   initial begin
      logic [15:0] lfsr;
      for (int j = 0; j < LINE; j++) hist[j] = 0;
      repeat (3) @(posedge clk);
      // R9: outputs held at zero during reset
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         n_chk++;
         if (gain !== '0) begin
            n_bad++;
            $display("FAIL R9: gain actual %h expected %h", gain, {OW{1'b0}});
         end
      end
      rst = 1'b0;
      // fill every table with distinct contents (no checks yet)
      for (int t = 0; t < NT; t++)
         for (int a = 0; a < DEPTH; a++)
            step("init", 0, 0, 0, 0, 1, t, a, (t + 1) * 256 + a, 0);
      step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
      // R1: mapping, zero and bin boundaries
      step("R1", 0, 0, 100, 0, 0, 0, 0, 0, 1);
      step("R1", 0, 100, 10, 10, 0, 0, 0, 0, 1);
      step("R1", 22, 0, 23, 0, 0, 0, 0, 0, 1);
      step("R1", 0, -23, -22, 0, 0, 0, 0, 0, 1);
      // R2: saturation at full scale
      step("R2", -128, -128, 127, 127, 0, 0, 0, 0, 1);
      step("R2", -128, 0, -128, -128, 0, 0, 0, 0, 1);
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1);
      step("R2", 0, 0, 0, 0, 0, 0, 0, 0, 1);
      // R4: distinct samples ripple through the taps
      for (int k = 1; k <= 8; k++)
         step("R4", k * 16 - 8, 0, k * 14, 20, 0, 0, 0, 0, 1);
      // R8: both phases see the same sample
      for (int k = 0; k < 3; k++)
         step("R8", 60, 40, 60, 40, 0, 0, 0, 0, 1);
      // steady sample of index 20, then updates to it
      for (int k = 0; k < 3; k++)
         step("R3", 90, -50, 90, -50, 0, 0, 0, 0, 1);
      step("R7", 90, -50, 90, -50, 0, 0, 0, 0, 1);
      step("R6", 90, -50, 90, -50, 1, 1, 20, 16'hBEEF, 1);
      step("R7", 90, -50, 90, -50, 0, 0, 0, 0, 1);
      step("R6", 90, -50, 90, -50, 1, 0, 20, 16'h1234, 1);
      step("R6", 90, -50, 90, -50, 0, 0, 0, 0, 1);
      // R5: write to another tap / an unread entry / a nonexistent tap
      step("R5", 90, -50, 90, -50, 1, 2, 5, 16'hCAFE, 1);
      step("R5", 90, -50, 90, -50, 1, 3, 20, 16'h0000, 1);
      for (int k = 0; k < 4; k++)
         step("R5", 52, 0, 52, 0, 0, 0, 0, 0, 1);
      for (int k = 0; k < 3; k++)
         step("R5", 90, -50, 52, 0, 0, 0, 0, 0, 1);
      // R3: long mixed run with occasional writes
      lfsr = 16'hACE1;
      for (int k = 0; k < 400; k++) begin
         int r0, q0, r1, q1;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         r0 = int'($signed(lfsr[7:0]));
         q0 = int'($signed(lfsr[15:8]));
         r1 = int'($signed(lfsr[11:4]));
         q1 = int'($signed(lfsr[14:7]));
         step("R3", r0, q0, r1, q1, (k % 7) == 3, k % 3, int'(lfsr[5:0]), int'(lfsr), 1);
      end
      step("R3", 0, 0, 0, 0, 0, 0, 0, 0, 1);
      repeat (4) @(negedge clk);
      if (exp_q.size() != 0) begin
         n_chk++;
         n_bad++;
         $display("FAIL R3: pending items actual %0d expected %0d", exp_q.size(), 0);
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: cycles actual %0d expected fewer", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule